// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block holds a bank of single-bit storage cells that are written one at a time. A single data bit and a binary address pick which cell changes. Two active-low controls choose what happens at each clock edge. The write strobe (`wr_n`) and the conditional clear (`clr_n`) together give four modes: keep everything, write the addressed cell, clear everything, or act as a one-hot demultiplexer. In demultiplexer mode every cell except the addressed one is cleared, and the addressed cell takes the data bit.

The block is fully synchronous. All inputs are sampled on the rising clock edge, and the output register is updated on that same edge. The effect of a mode is therefore visible one clock after its inputs are applied. Holding `wr_n` low over several cycles models a transparent latch: the addressed cell follows the data bit on each cycle. When the strobe is released, the cell keeps the last value it sampled.

The address should only move while `wr_n` is high. A one-cycle warning output marks any address change between two consecutive cycles in which the strobe was low.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst_n` is sampled low, the next clock edge sets `q` to all zeros and `addr_warn` to 0.
- R2: Address value k (with `addr[ADDR_W-1]` as the most significant bit) selects output bit `q[k]`, for every k from 0 to 2^ADDR_W-1.
- R3: With `wr_n`=1 and `clr_n`=1 sampled, `q` keeps its value on the next edge, whatever `din` and `addr` are.
- R4: With `wr_n`=0 and `clr_n`=1 sampled, the next edge loads `din` into `q[addr]`, and every other bit of `q` keeps its value.
- R5: After a run of write cycles to one address ends with `wr_n` returning high, that bit keeps the `din` value sampled in the last write cycle.
- R6: With `wr_n`=1 and `clr_n`=0 sampled, every bit of `q` is 0 after the next edge.
- R7: With `wr_n`=0 and `clr_n`=0 sampled, after the next edge `q[addr]` equals `din` and every other bit is 0. The result is one-hot when `din`=1 and all zero when `din`=0.
- R8: After demultiplexer mode, a following hold cycle keeps the last one-hot or all-zero pattern unchanged.
- R9: `addr_warn` is 1 for exactly one cycle after an edge where `wr_n` was sampled low on both that edge and the previous one, with different `addr` values on the two edges. Otherwise it is 0.
- R10: Reset takes priority over every mode, including demultiplexer mode with `din`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Data bit written to the addressed cell |
| addr | input | ADDR_W (3) | Binary cell address, MSB first |
| wr_n | input | 1 | Active-low write strobe |
| clr_n | input | 1 | Active-low conditional clear |
| q | output | 2^ADDR_W (8) | Stored cell values, bit k is cell k |
| addr_warn | output | 1 | One-cycle pulse: address moved while strobe held low |

## Verification
Each cell holds its value with no refresh, so a wrong internal state stays visible on `q` and does not correct itself. A wrong decoder line or a wrong mode decode shows up on the `q` bits one cycle after the stimulus. If the corrupted bit is then only held, the error persists until that cell is written again or cleared. An error in the address-change tracking shows as a missing or extra `addr_warn` pulse one cycle after the second strobed cycle. Random mixing of all four modes, compared every cycle against a reference model, catches a corrupted bit within the cycle after it goes wrong.

// File: rtl/latch_pkg.sv
// Package: shared mode type for the addressable latch.
// Assumes: controls are active-low, as at the top-level ports.
package latch_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } latch_mode_e;

endpackage

// File: rtl/latch_mode_dec.sv
// Module: latch_mode_dec
// Turns the two active-low controls into one of four operating modes.
// Assumes: inputs are already synchronous to the block clock.
module latch_mode_dec
    import latch_pkg::*;
(
    input  logic        wr_n,
    input  logic        clr_n,
    output latch_mode_e mode
);

    // Purpose: map the strobe/clear pair onto a mode.
    always_comb begin
        case ({wr_n, clr_n})
            2'b11:   mode = MODE_HOLD;
            2'b01:   mode = MODE_WRITE;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/latch_addr_dec.sv
// Module: latch_addr_dec
// Binary-to-one-hot decoder: line k is high when addr equals k.
// Assumes: N_OUT equals 2**ADDR_W.
module latch_addr_dec #(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_OUT-1:0]  sel
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        // Purpose: raise decoder line k on a matching address.
        always_comb sel[k] = (addr == ADDR_W'(k));
    end

endmodule

// File: rtl/latch_bit_cell.sv
// Module: latch_bit_cell
// One storage cell. It updates from the mode, its select line and the data bit.
// Assumes: sel is one-hot across the bank; synchronous active-low reset.
module latch_bit_cell
    import latch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  latch_mode_e mode,
    input  logic        sel,
    input  logic        din,
    output logic        q
);

    logic q_nxt;

    // Purpose: next value of the cell for each mode.
    always_comb begin
        case (mode)
            MODE_HOLD:  q_nxt = q;
            MODE_WRITE: q_nxt = sel ? din : q;
            MODE_DEMUX: q_nxt = sel & din;
            default:    q_nxt = 1'b0;
        endcase
    end

    // Purpose: register the cell, reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/latch_addr_watch.sv
// Module: latch_addr_watch
// Flags an address change between two consecutive strobed cycles.
// Assumes: the warning is informative only and gates nothing.
module latch_addr_watch #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              warn
);

    logic              strobe_prev;
    logic [ADDR_W-1:0] addr_prev;

    // Purpose: remember last strobe/address and raise a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_prev <= 1'b0;
            addr_prev   <= '0;
            warn        <= 1'b0;
        end else begin
            strobe_prev <= !wr_n;
            addr_prev   <= addr;
            warn        <= !wr_n && strobe_prev && (addr != addr_prev);
        end
    end

endmodule

// File: rtl/addr_latch_demux.sv
// Module: addr_latch_demux (top)
// Bank of 2**ADDR_W single-bit cells written by address, with hold, write,
// demultiplexer and clear modes, plus an address-change warning.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module addr_latch_demux
    import latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic              clr_n,
    output logic [N_OUT-1:0]  q,
    output logic              addr_warn
);

    latch_mode_e      mode;
    logic [N_OUT-1:0] sel;

    latch_mode_dec u_mode (
        .wr_n  (wr_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    latch_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_cell
        latch_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .sel   (sel[k]),
            .din   (din),
            .q     (q[k])
        );
    end

    latch_addr_watch #(.ADDR_W(ADDR_W)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_n  (wr_n),
        .addr  (addr),
        .warn  (addr_warn)
    );

endmodule

// File: rtl/addr_latch_demux_chk.sv
// Module: addr_latch_demux_chk
// Port-level temporal checks for addr_latch_demux, attached by bind.
// Assumes: reset is applied from time zero.
module addr_latch_demux_chk #(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_n,
    input logic              clr_n,
    input logic [N_OUT-1:0]  q,
    input logic              addr_warn
);

    localparam logic [N_OUT-1:0] ONE = N_OUT'(1);

    // R1 / R10: reset wins over any mode
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0 && !addr_warn));

    a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_n) && $past(clr_n)) |-> (q == $past(q)));

    a_r4_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_n) && $past(clr_n)) |->
        ((q[$past(addr)] == $past(din)) &&
         (((q ^ $past(q)) & ~(ONE << $past(addr))) == '0)));

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_n) && !$past(clr_n)) |-> (q == '0));

    a_r7_demux_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_n) && !$past(clr_n)) |->
        (($countones(q) == ($past(din) ? 1 : 0)) && (q[$past(addr)] == $past(din))));

    a_r9_warn_cause: assert property (@(posedge clk) disable iff (!rst_n)
        addr_warn |-> ($past(rst_n) && $past(rst_n, 2) && !$past(wr_n) &&
                       !$past(wr_n, 2) && ($past(addr) != $past(addr, 2))));

    a_r9_warn_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_warn |=> (!addr_warn || ($past(addr) != $past(addr, 2))));

endmodule

bind addr_latch_demux addr_latch_demux_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .addr      (addr),
    .wr_n      (wr_n),
    .clr_n     (clr_n),
    .q         (q),
    .addr_warn (addr_warn)
);

// File: tb/addr_latch_demux_tb.sv
module addr_latch_demux_tb;

    localparam int AW = 3;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, din, wr_n, clr_n;
    logic [AW-1:0] addr;
    logic [N-1:0]  q;
    logic          addr_warn;

    int            n_cmp = 0;
    int            n_bad = 0;
    logic [N-1:0]  exp_q;
    logic          exp_warn;
    logic          m_strobe_prev;
    logic [AW-1:0] m_addr_prev;

    always #10 clk = ~clk;

    addr_latch_demux #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
        .wr_n(wr_n), .clr_n(clr_n), .q(q), .addr_warn(addr_warn)
    );

    // Reference next state from the requirements.
    function automatic logic [N-1:0] ref_q(input logic [N-1:0] cur, input logic w,
                                           input logic c, input logic d, input logic [AW-1:0] a);
        logic [N-1:0] r;
        r = cur;
        if (w && !c)       r = '0;
        else if (!w && c)  r[a] = d;
        else if (!w && !c) begin r = '0; r[a] = d; end
        return r;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic apply(input logic r, input logic w, input logic c, input logic d,
                         input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        rst_n = r; wr_n = w; clr_n = c; din = d; addr = a;
        if (!r) begin
            exp_q = '0; exp_warn = 1'b0; m_strobe_prev = 1'b0; m_addr_prev = '0;
        end else begin
            exp_q    = ref_q(exp_q, w, c, d, a);
            exp_warn = !w && m_strobe_prev && (a != m_addr_prev);
            m_strobe_prev = !w;
            m_addr_prev   = a;
        end
        @(posedge clk);
        #3;
        n_cmp++;
        if (q !== exp_q || addr_warn !== exp_warn) begin
            n_bad++;
            $display("FAIL %s: q=%h expected %h, warn=%b expected %b",
                     tag, q, exp_q, addr_warn, exp_warn);
        end
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_n = 1'b1; clr_n = 1'b1; din = 1'b0; addr = '0;
        exp_q = '0; exp_warn = 1'b0; m_strobe_prev = 1'b0; m_addr_prev = '0;

        apply(0, 1, 1, 0, 0, "R1 reset state");
        apply(0, 0, 0, 1, 5, "R10 reset beats demux");

        // R2: walk a one through every address with release cycles between
        for (int k = 0; k < N; k++) begin
            apply(1, 0, 1, 1, AW'(k), "R2 write address map");
            apply(1, 1, 1, 0, AW'(k), "R2 release");
        end
        // R3: hold ignores data and address
        for (int k = 0; k < 6; k++)
            apply(1, 1, 1, 1'($urandom), AW'($urandom), "R3 hold ignores inputs");
        // R4: clear one bit, others kept
        apply(1, 0, 1, 0, 3, "R4 write zero to one cell");
        apply(1, 1, 1, 1, 3, "R4 release");
        // R5: last sampled value before release is kept
        apply(1, 0, 1, 0, 6, "R5 strobe low, din 0");
        apply(1, 0, 1, 1, 6, "R5 strobe low, din 1");
        apply(1, 1, 1, 0, 6, "R5 released keeps 1");
        apply(1, 1, 1, 0, 2, "R5 still kept");
        // R6: clear all
        apply(1, 1, 0, 1, 4, "R6 clear all");
        // R7/R8: demux one-hot then hold
        apply(1, 0, 0, 1, 7, "R7 demux one-hot");
        apply(1, 1, 1, 0, 0, "R8 hold after demux one-hot");
        apply(1, 0, 0, 1, 1, "R7 demux one-hot moved");
        apply(1, 1, 1, 1, 1, "R9 release between demux");
        apply(1, 0, 0, 0, 1, "R7 demux zero");
        apply(1, 1, 1, 1, 5, "R8 hold after demux zero");
        // R9: address moves while strobe stays low
        apply(1, 0, 1, 1, 2, "R9 first strobed cycle");
        apply(1, 0, 1, 1, 2, "R9 same address no warn");
        apply(1, 0, 1, 0, 4, "R9 moved address warns");
        apply(1, 0, 1, 0, 4, "R9 warn lasts one cycle");
        apply(1, 1, 1, 0, 1, "R9 release no warn");

        // Random mix of all modes, with occasional reset
        for (int i = 0; i < 600; i++) begin
            logic w, c, r;
            string tag;
            r = ($urandom % 50) != 0;
            w = 1'($urandom);
            c = ($urandom % 4) != 0;
            if (!r)            tag = "R10 random reset";
            else if (w && c)   tag = "R3 random hold";
            else if (!w && c)  tag = "R4 R9 random write";
            else if (!w && !c) tag = "R7 random demux";
            else               tag = "R6 random clear";
            apply(r, w, c, 1'($urandom), AW'($urandom), tag);
        end

        summary();
        $finish;
    end

endmodule